// File: doc/BRIEF.md
# Write-Cycle Status Read Logic

This block sits in the read path of a byte-wide nonvolatile memory and tells a host when an internal write is complete. It uses the ordinary data bus for this and needs no ready pin. While the write controller reports that programming is running, any read returns a status byte instead of array contents. The top bit of that byte is the inverse of the top bit of the last byte written. The next bit changes value on every read. Once programming ends, reads return the stored array data again and the changing bit stops.

The host can finish a write in either of two ways. It can poll until the top bit matches what it wrote, or it can read twice in a row until the changing bit stays the same. Two flags come from the write controller. The first is a busy flag. The second is a flag that marks a write which was refused because the device is protected. During a refused write the top bit shows the written value without inversion, so polling gives no completion signal. The read strobe is formed from active-low chip enable, active-low output enable and active-low write enable. A read is active when both enables are low and write enable is high. The block counts one read access each time that combined strobe ends.

Top module: `wrstat_read`

## Requirements
- R1: While a read is active and programming is not running, `dq_out` equals `array_rdata` and `dq_oe` is 1.
- R2: While a read is active, programming is running and the write was not refused, `dq_out[7]` is the inverse of `last_wr_msb`.
- R3: While programming is running, a read drives the toggle bit `dq_out[6]`. Its value changes each time a read access ends. A read access ends when the combined strobe goes from active to inactive and `busy` is high at that clock.
- R4: When a read access ends while `busy` is low, the toggle state does not change. The next status read continues the sequence where it left off.
- R5: During a status read, bits 5 through 0 of `dq_out` are 0.
- R6: When `wr_blocked` is high during a status read, `dq_out[7]` equals `last_wr_msb` without inversion.
- R7: When no read is active, `dq_oe` is 0 and `dq_out` is 0. This covers the cases where chip enable is high, output enable is high, or write enable is low. Such a strobe pattern does not advance the toggle state.
- R8: A synchronous active-low reset clears the toggle state, so the first status read after reset shows 1 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| wr_blocked | input | 1 | Current write was refused because the device is protected |
| last_wr_msb | input | 1 | Bit 7 of the last byte written |
| array_rdata | input | 8 | Data read from the array at the current address |
| dq_out | output | 8 | Byte driven onto the data bus |
| dq_oe | output | 1 | Data bus output enable |

## Verification
If the toggle state is wrong, the port shows it on the very next status read. Bit 6 is then inverted from the value the bench has tracked. A strobe that moves the toggle state when it should not, such as a write-enable pulse or a read that ends while the block is idle, is also caught at that next read. A wrong source select or a bit at the wrong position shows up as a whole-byte mismatch in the same read in which it occurs.

// File: rtl/wrstat_pkg.sv
// Package: shared constants and types for the write-status read path.
// Assumes a byte-wide bus. The polling and toggle bit positions are fixed
// by the host-visible protocol.
package wrstat_pkg;
    localparam int unsigned BUS_W      = 8;
    localparam int unsigned POLL_POS   = 7;
    localparam int unsigned TOGGLE_POS = 6;

    // Source of the byte driven on the bus.
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;
endpackage

// File: rtl/wrstat_strobe.sv
// Module: decodes the combined read strobe from the three control pins and
// flags the cycle in which a read access ends.
// Assumes the pins are already synchronous to clk.
module wrstat_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_act,
    output logic rd_end
);
    logic rd_q;

    // Read is active with both enables low and write enable high.
    always_comb rd_act = ~ce_n & ~oe_n & we_n;

    // Remember the strobe level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_act;
    end

    // Falling edge of the combined strobe marks the end of one access.
    always_comb rd_end = rd_q & ~rd_act;
endmodule

// File: rtl/wrstat_toggle.sv
// Module: the toggle state, which inverts once per read access completed
// while programming runs and holds otherwise.
// Assumes busy is stable across the end of an access.
module wrstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_end,
    input  logic busy,
    output logic tog_q
);
    // Advance only on an access that ends during programming.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog_q <= 1'b0;
        else if (rd_end && busy) tog_q <= ~tog_q;
    end
endmodule

// File: rtl/wrstat_compose.sv
// Module: builds the status byte. It places the polling bit and the
// toggle bit and drives the reserved bits to zero.
// Assumes POLL_POS and TOGGLE_POS differ and both lie inside DATA_W.
module wrstat_compose #(
    parameter int unsigned DATA_W     = wrstat_pkg::BUS_W,
    parameter int unsigned POLL_POS   = wrstat_pkg::POLL_POS,
    parameter int unsigned TOGGLE_POS = wrstat_pkg::TOGGLE_POS
) (
    input  logic              last_msb,
    input  logic              poll_en,
    input  logic              tog_q,
    output logic [DATA_W-1:0] status
);
    logic poll_bit;
    logic tog_bit;

    // Invert the written bit only when polling is allowed.
    always_comb poll_bit = poll_en ? ~last_msb : last_msb;
    // A cleared toggle state reads as 1, so the first status read shows 1.
    always_comb tog_bit  = ~tog_q;

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_bit
            if (b == POLL_POS) begin : g_poll
                assign status[b] = poll_bit;
            end else if (b == TOGGLE_POS) begin : g_tog
                assign status[b] = tog_bit;
            end else begin : g_rsv
                assign status[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/wrstat_read.sv
// Module: top of the write-status read path. It chooses between array data
// and the status byte and drives the bus enable.
// Assumes the write controller holds busy, wr_blocked and last_wr_msb
// for the whole programming cycle.
module wrstat_read #(
    parameter int unsigned DATA_W     = wrstat_pkg::BUS_W,
    parameter int unsigned POLL_POS   = wrstat_pkg::POLL_POS,
    parameter int unsigned TOGGLE_POS = wrstat_pkg::TOGGLE_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic              wr_blocked,
    input  logic              last_wr_msb,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    import wrstat_pkg::*;

    logic              rd_act;
    logic              rd_end;
    logic              tog_state;
    logic [DATA_W-1:0] status_byte;
    rd_src_e           src;

    wrstat_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_act (rd_act),
        .rd_end (rd_end)
    );

    wrstat_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_end (rd_end),
        .busy   (busy),
        .tog_q  (tog_state)
    );

    wrstat_compose #(
        .DATA_W     (DATA_W),
        .POLL_POS   (POLL_POS),
        .TOGGLE_POS (TOGGLE_POS)
    ) u_compose (
        .last_msb (last_wr_msb),
        .poll_en  (~wr_blocked),
        .tog_q    (tog_state),
        .status   (status_byte)
    );

    // Select what the bus carries for this cycle.
    always_comb begin
        if (!rd_act)   src = SRC_IDLE;
        else if (busy) src = SRC_STATUS;
        else           src = SRC_ARRAY;
    end

    // Drive the bus from the selected source.
    always_comb begin
        case (src)
            SRC_ARRAY:  dq_out = array_rdata;
            SRC_STATUS: dq_out = status_byte;
            default:    dq_out = '0;
        endcase
        dq_oe = (src != SRC_IDLE);
    end
endmodule

// File: rtl/wrstat_read_chk.sv
// Module: property checker for wrstat_read. It is bound to the top and
// watches the ports and the toggle state.
// Assumes the reset is held for at least one clock at start-up.
module wrstat_read_chk #(
    parameter int unsigned DATA_W     = wrstat_pkg::BUS_W,
    parameter int unsigned POLL_POS   = wrstat_pkg::POLL_POS,
    parameter int unsigned TOGGLE_POS = wrstat_pkg::TOGGLE_POS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic              wr_blocked,
    input logic              last_wr_msb,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              tog_state
);
    logic rd_on;
    always_comb rd_on = !ce_n && !oe_n && we_n;

    // R1: array data passes through when idle.
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && !busy) |-> (dq_oe && dq_out == array_rdata));

    // R2: the polling bit is inverted during programming.
    p_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && busy && !wr_blocked) |-> (dq_out[POLL_POS] != last_wr_msb));

    // R3: the toggle state flips after an access ends during programming.
    p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_on) && !rd_on && busy) |=> (tog_state != $past(tog_state)));

    // R4 and R7: the toggle state holds in every other case.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(rd_on) && !rd_on && busy) |=> $stable(tog_state));

    // R5: the reserved bits are zero during a status read.
    p_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && busy) |-> ($countones(dq_out) <= 2 &&
            (dq_out & ~((DATA_W'(1) << POLL_POS) | (DATA_W'(1) << TOGGLE_POS))) == '0));

    // R6: a refused write leaves the polling bit uninverted.
    p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && busy && wr_blocked) |-> (dq_out[POLL_POS] == last_wr_msb));

    // R7: the bus stays quiet with no read active.
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_on |-> (!dq_oe && dq_out == '0));
endmodule

bind wrstat_read wrstat_read_chk #(
    .DATA_W     (DATA_W),
    .POLL_POS   (POLL_POS),
    .TOGGLE_POS (TOGGLE_POS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .busy        (busy),
    .wr_blocked  (wr_blocked),
    .last_wr_msb (last_wr_msb),
    .array_rdata (array_rdata),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .tog_state   (tog_state)
);

// File: tb/wrstat_read_tb.sv
// Bench: directed corner cases followed by seeded random accesses. It keeps
// its own model of the toggle state.
module wrstat_read_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic       busy = 1'b0, wr_blocked = 1'b0, last_wr_msb = 1'b0;
    logic [7:0] array_rdata = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;

    int checks = 0;
    int failures = 0;
    logic tog_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrstat_read u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .wr_blocked(wr_blocked), .last_wr_msb(last_wr_msb),
        .array_rdata(array_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one read access and compare the byte with the requirements.
    task automatic do_read(input logic b, input logic blk, input logic msb, input logic [7:0] arr);
        @(negedge clk);
        busy = b; wr_blocked = blk; last_wr_msb = msb; array_rdata = arr;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        chk("R1 oe", {7'd0, dq_oe}, 8'd1);
        if (!b) chk("R1", dq_out, arr);
        else begin
            chk(blk ? "R6" : "R2", {7'd0, dq_out[7]}, {7'd0, blk ? msb : ~msb});
            chk("R3", {7'd0, dq_out[6]}, {7'd0, ~tog_m});
            chk("R5", {2'd0, dq_out[5:0]}, 8'd0);
        end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        if (b) tog_m = ~tog_m;   // flips at the next edge, before the next read
    endtask

    // Apply a pattern that is not a read. The bus must stay quiet.
    task automatic no_read(input logic [1:0] kind, input logic b);
        @(negedge clk);
        busy = b;
        case (kind)
            2'd0: begin ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; end
            2'd1: begin ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; end
            default: begin ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; end
        endcase
        #1;
        chk("R7", {dq_oe, 7'd0} | dq_out, 8'd0);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        chk("R8 reset quiet", {dq_oe, 7'd0}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: the first status read after reset shows 1 on the toggle bit.
        do_read(1'b1, 1'b0, 1'b0, 8'h5A);
        chk("R8 tog after reset", {7'd0, tog_m}, 8'd1);
        do_read(1'b1, 1'b0, 1'b1, 8'h00);   // R3: second read shows 0
        do_read(1'b1, 1'b1, 1'b1, 8'h00);   // R6: refused write
        do_read(1'b1, 1'b1, 1'b0, 8'h00);   // R6
        // R4: idle reads do not move the state. The next status read resumes.
        do_read(1'b0, 1'b0, 1'b0, 8'hA5);
        do_read(1'b0, 1'b0, 1'b1, 8'hFF);
        do_read(1'b1, 1'b0, 1'b0, 8'h00);
        // R7: a write pulse and a deselected chip during programming do not count.
        no_read(2'd2, 1'b1);
        no_read(2'd0, 1'b1);
        do_read(1'b1, 1'b0, 1'b1, 8'h00);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (r[7:6] == 2'b00) no_read(r[1:0], r[2]);
            else do_read(r[3], r[4], r[5], 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule